// File: doc/BRIEF.md
# Stream end-of-packet escape encoder

This block turns a 64-bit valid/ready stream that carries an end-of-packet sideband flag into a 64-bit valid/ready stream that has no such flag. Packet boundaries are instead marked inside the data by a reserved escape word, `0xDEADBEEFFEEDCAFE`. A word that ends a packet goes out as three words: the escape word, a control word that marks the end of the packet, and then the word itself. A data word whose value happens to equal the escape word also goes out as three words: the escape word, an all-zero control word that marks literal data, and then the word itself. Every other word passes through unchanged, with no added latency.

The end-of-packet control word carries a 32-bit running checksum in its upper half. This lets a downstream decoder check that it received the whole packet body. The block sits at the point where a packet stream leaves a domain that can carry the flag and enters a transport that can only move plain data words.

Top module: `tlast_esc_encoder`

## Requirements
- R1: An accepted input word whose end flag is clear and whose value is not `0xDEADBEEFFEEDCAFE` appears once on the output, unchanged, in the same cycle that it is accepted.
- R2: An input word whose end flag is set is emitted as three output words in this order: `0xDEADBEEFFEEDCAFE`, a control word whose bits [31:0] equal 1, and then the input word.
- R3: An input word whose end flag is clear and whose value equals `0xDEADBEEFFEEDCAFE` is emitted as `0xDEADBEEFFEEDCAFE`, then an all-zero control word, then `0xDEADBEEFFEEDCAFE` again.
- R4: Bits [63:32] of an end-of-packet control word equal the modulo-2^32 sum of bits [31:0] and bits [63:32] of every word accepted earlier in the same packet. Each word counts exactly once, including words equal to the escape value. The final word itself is not counted.
- R5: After the final word of a packet is accepted, the checksum restarts from zero. A packet made of a single word therefore carries a checksum of 0.
- R6: A one-cycle synchronous `clr` pulse returns the block to pass-through and sets the checksum to zero.
- R7: `in_ready` is low in every cycle in which the escape word or the control word is being offered on the output. The input word is accepted only in the cycle in which it is itself emitted.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays the same in the next cycle. No output word is dropped or repeated.
- R9: A final word whose value equals `0xDEADBEEFFEEDCAFE` is encoded with the end-of-packet control word (bits [31:0] = 1), not the literal control word.
- R10: While `rst_n` is low, and after reset with no input offered, `out_valid` is low and the checksum is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of the state machine and the checksum |
| in_data | input | 64 | Input data word |
| in_last | input | 1 | Input word ends a packet |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted when high together with `in_valid` |
| out_data | output | 64 | Encoded output word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream takes the output word |

## Verification
The assertions assume that the upstream side keeps to the valid/ready rules. Once `in_valid` is raised, it stays high, and `in_data` and `in_last` stay stable, until the word is accepted. The output-stability property and the control-word checks depend on this, because the escape and control words are built from the held input. The bench drives random data, random end flags, random idle gaps and random `out_ready` backpressure. It changes a word only after that word's acceptance has been seen, so the stimulus stays within this rule. `clr` is pulsed only while no input word is pending.

// File: rtl/tlenc_pkg.sv
// Package tlenc_pkg
// Shared types and constants for the in-band end-of-packet encoder.
// Assumes a data word made of two equal halves; the checksum is one half wide.
package tlenc_pkg;

    localparam int unsigned       DATA_W_DEF = 64;
    localparam logic [63:0]       ESC_WORD_DEF = 64'hDEADBEEFFEEDCAFE;

    // Encoder control states
    typedef enum logic [1:0] {
        ST_PASS = 2'd0,   // words pass straight through
        ST_ESC  = 2'd1,   // escape word held under backpressure
        ST_CTRL = 2'd2,   // control word being offered
        ST_DATA = 2'd3    // original word being offered after escape
    } enc_state_t;

    // Output multiplexer select
    typedef enum logic [1:0] {
        SEL_IN   = 2'd0,
        SEL_ESC  = 2'd1,
        SEL_CTRL = 2'd2
    } out_sel_t;

endpackage

// File: rtl/tlenc_detect.sv
// Module tlenc_detect
// Decides whether the offered input word needs a three-word expansion.
// A word needs one when it ends a packet or when it equals the escape word.
// Purely combinational; assumes in_data is stable while in_valid is held.
module tlenc_detect #(
    parameter int unsigned      DATA_W   = 64,
    parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              is_esc,
    output logic              need_exp
);

    // compare against the reserved word and flag expansion
    always_comb begin
        is_esc   = (in_data == ESC_WORD);
        need_exp = in_valid && (in_last || is_esc);
    end

endmodule

// File: rtl/tlenc_csum.sv
// Module tlenc_csum
// Running per-packet checksum: modulo 2^CSUM_W sum of both halves of
// every accepted word before the final one. It restarts after the final
// word is accepted, on reset and on clear.
// Assumes accept is the input handshake of the encoder.
module tlenc_csum #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned CSUM_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              accept,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic [CSUM_W-1:0] csum
);

    logic [CSUM_W-1:0] lo_half;
    logic [CSUM_W-1:0] hi_half;
    logic [CSUM_W-1:0] csum_sum;

    // split the word and form the updated sum
    always_comb begin
        lo_half  = in_data[CSUM_W-1:0];
        hi_half  = in_data[DATA_W-1:CSUM_W];
        csum_sum = csum + lo_half + hi_half;
    end

    // accumulate body words, restart on the final word
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            csum <= '0;
        end else if (accept && in_last) begin
            csum <= '0;
        end else if (accept) begin
            csum <= csum_sum;
        end
    end

    // R5
    csum_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last && !clr) |=> (csum == '0));

    // R6
    csum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (csum == '0));

endmodule

// File: rtl/tlenc_fsm.sv
// Module tlenc_fsm
// Sequencer for the three-word expansion. It chooses what the output
// shows and drives both handshake outputs. It assumes the input word and
// its end flag are held stable until they are accepted.
module tlenc_fsm
    import tlenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       in_valid,
    input  logic       need_exp,
    input  logic       out_ready,
    output logic       in_ready,
    output logic       out_valid,
    output out_sel_t   sel,
    output enc_state_t state
);

    enc_state_t nxt;

    // next state, output select and handshakes
    always_comb begin
        nxt       = state;
        sel       = SEL_IN;
        out_valid = in_valid;
        in_ready  = out_ready;
        unique case (state)
            ST_PASS: begin
                if (need_exp) begin
                    sel       = SEL_ESC;
                    out_valid = 1'b1;
                    in_ready  = 1'b0;
                    nxt       = out_ready ? ST_CTRL : ST_ESC;
                end
            end
            ST_ESC: begin
                sel       = SEL_ESC;
                out_valid = 1'b1;
                in_ready  = 1'b0;
                if (out_ready) nxt = ST_CTRL;
            end
            ST_CTRL: begin
                sel       = SEL_CTRL;
                out_valid = 1'b1;
                in_ready  = 1'b0;
                if (out_ready) nxt = ST_DATA;
            end
            ST_DATA: begin
                if (in_valid && out_ready) nxt = ST_PASS;
            end
            default: nxt = ST_PASS;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= ST_PASS;
        else               state <= nxt;
    end

    // R2
    ctrl_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && out_ready && !clr) |=> (state == ST_DATA));

    // R8
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && !out_ready && !clr) |=> (state == ST_CTRL));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state == ST_PASS));

endmodule

// File: rtl/tlast_esc_encoder.sv
// Module tlast_esc_encoder
// Top level: removes the end-of-packet sideband and marks boundaries and
// escape-valued data in band. Pass-through words have no added latency.
// Assumes the upstream keeps to the valid/ready rules (held data while
// valid and not ready).
module tlast_esc_encoder
    import tlenc_pkg::*;
#(
    parameter int unsigned       DATA_W   = DATA_W_DEF,
    parameter logic [DATA_W-1:0] ESC_WORD = ESC_WORD_DEF,
    localparam int unsigned      CSUM_W   = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    logic              is_esc;
    logic              need_exp;
    logic              accept;
    logic [CSUM_W-1:0] csum;
    logic [DATA_W-1:0] ctrl_word;
    out_sel_t          sel;
    enc_state_t        state;

    tlenc_detect #(.DATA_W(DATA_W), .ESC_WORD(ESC_WORD)) u_detect (
        .in_data  (in_data),
        .in_last  (in_last),
        .in_valid (in_valid),
        .is_esc   (is_esc),
        .need_exp (need_exp)
    );

    tlenc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_valid  (in_valid),
        .need_exp  (need_exp),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .sel       (sel),
        .state     (state)
    );

    // input handshake used by the checksum
    always_comb accept = in_valid && in_ready;

    tlenc_csum #(.DATA_W(DATA_W)) u_csum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .accept  (accept),
        .in_last (in_last),
        .in_data (in_data),
        .csum    (csum)
    );

    // control word: checksum and end flag for a final word, zero otherwise
    always_comb begin
        ctrl_word = '0;
        if (in_last) begin
            ctrl_word[DATA_W-1:CSUM_W] = csum;
            ctrl_word[0]               = 1'b1;
        end
    end

    // output multiplexer
    always_comb begin
        unique case (sel)
            SEL_ESC:  out_data = ESC_WORD;
            SEL_CTRL: out_data = ctrl_word;
            default:  out_data = in_data;
        endcase
    end

    // R8
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    accept_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (out_valid && out_ready && out_data == in_data));

    // R1
    plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && in_valid && !in_last && !is_esc)
            |-> (out_valid && out_data == in_data));

    // R3
    literal_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && in_valid && !in_last) |-> (out_data == '0));

    // R9
    eop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && in_valid && in_last) |-> (out_data[CSUM_W-1:0] == 1));

endmodule

// File: tb/tlast_esc_encoder_bench.sv
module tlast_esc_encoder_bench;

    localparam logic [63:0] ESC = 64'hDEADBEEFFEEDCAFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tlast_esc_encoder u_tlast_esc_encoder (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_data(in_data), .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    // kinds: 0 plain, 1 escape, 2 eop ctrl, 3 literal ctrl, 4 expanded data
    logic [63:0] exp_data[$];
    int          exp_kind[$];
    logic [63:0] stim_data[$];
    bit          stim_last[$];
    logic [31:0] model_csum = '0;
    bit          took = 0;
    bit          stall_prev = 0;
    logic [63:0] data_prev = '0;
    int          ready_pct = 75;
    int          gap_pct = 20;

    function automatic string req_of(int k);
        case (k)
            0: return "R1";
            1: return "R2/R3 escape";
            2: return "R4 eop ctrl";
            3: return "R3 literal ctrl";
            default: return "R2 data";
        endcase
    endfunction

    function automatic logic [31:0] csum_add(logic [31:0] c, logic [63:0] d);
        return c + d[31:0] + d[63:32];
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // build the expected output words for one input word
    task automatic push_word(logic [63:0] d, bit last);
        stim_data.push_back(d);
        stim_last.push_back(last);
        if (last) begin
            exp_data.push_back(ESC);                 exp_kind.push_back(1);
            exp_data.push_back({model_csum, 32'h1}); exp_kind.push_back(2);
            exp_data.push_back(d);                   exp_kind.push_back(4);
            model_csum = '0;
        end else if (d == ESC) begin
            exp_data.push_back(ESC);   exp_kind.push_back(1);
            exp_data.push_back('0);    exp_kind.push_back(3);
            exp_data.push_back(d);     exp_kind.push_back(4);
            model_csum = csum_add(model_csum, d);
        end else begin
            exp_data.push_back(d);     exp_kind.push_back(0);
            model_csum = csum_add(model_csum, d);
        end
    endtask

    // driver: new word only after the previous one was accepted
    always @(posedge clk) begin
        #1;
        if (rst_n && !clr) begin
            if (took || !in_valid) begin
                if (stim_data.size() > 0 && ($urandom % 100) >= gap_pct) begin
                    in_data  = stim_data.pop_front();
                    in_last  = stim_last.pop_front();
                    in_valid = 1'b1;
                end else begin
                    in_valid = 1'b0;
                end
            end
            out_ready = (($urandom % 100) < ready_pct);
        end
        took = 0;
    end

    // monitor: sample away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !clr && !done) begin
            if (stall_prev)
                check(out_valid && out_data == data_prev, "R8 hold under backpressure",
                      out_data, data_prev);
            if (out_valid) begin
                if (exp_data.size() == 0) begin
                    check(0, "R1 unexpected output word", out_data, '0);
                end else begin
                    if (exp_kind[0] == 1 || exp_kind[0] == 2 || exp_kind[0] == 3)
                        check(!in_ready, "R7 input held during escape/control",
                              {63'b0, in_ready}, 64'd0);
                    if (out_ready) begin
                        check(out_data == exp_data[0], req_of(exp_kind[0]),
                              out_data, exp_data[0]);
                        void'(exp_data.pop_front());
                        void'(exp_kind.pop_front());
                    end
                end
            end
            if (in_valid && in_ready) took = 1;
            stall_prev = out_valid && !out_ready;
            data_prev  = out_data;
        end
        if (cycles > 150000 && !done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            done = 1;
        end
    end

    task automatic drain();
        while ((exp_data.size() > 0 || stim_data.size() > 0 || in_valid) && !done)
            @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic do_clear();
        drain();
        @(posedge clk); #1;
        clr = 1'b1;
        @(posedge clk); #1;
        clr = 1'b0;
        model_csum = '0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R10 out_valid in reset", {63'b0, out_valid}, 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R10 out_valid after reset", {63'b0, out_valid}, 64'd0);
        // R10: single-word packet right after reset carries checksum 0
        push_word(64'h0123456789ABCDEF, 1);
        drain();

        // directed corner cases
        push_word(64'h1, 0);                       // R1
        push_word(ESC, 0);                         // R3 literal, counted once (R4)
        push_word(64'hFFFFFFFF_FFFFFFFF, 0);       // R4 wraparound
        push_word(64'h5, 1);                       // R2 / R4
        push_word(64'h7, 1);                       // R5 single-word packet, csum 0
        push_word(ESC, 1);                         // R9 final escape value
        push_word(ESC, 0);
        push_word(ESC, 0);
        push_word(64'h0, 1);
        drain();

        // R6: clear mid-packet restarts the checksum
        push_word(64'h1111_1111_2222_2222, 0);
        push_word(64'h3333_3333_4444_4444, 0);
        do_clear();
        push_word(64'h10, 0);
        push_word(64'h20, 1);
        drain();

        // no backpressure pass
        ready_pct = 100; gap_pct = 0;
        for (int i = 0; i < 200; i++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            if ($urandom % 8 == 0) d = ESC;
            push_word(d, ($urandom % 5) == 0);
        end
        drain();

        // heavy backpressure and gaps
        ready_pct = 40; gap_pct = 30;
        for (int i = 0; i < 1500; i++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            if ($urandom % 6 == 0) d = ESC;
            push_word(d, ($urandom % 4) == 0);
            if (i % 500 == 499) do_clear();
        end
        drain();

        check(exp_data.size() == 0, "R8 no word lost", exp_data.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule